// File: doc/BRIEF.md
# Delay-Compensated Interleaver Address Sequencer

This block supplies the addresses for the two data RAMs of one turbo decoding stage. The interleaver RAM is written in natural order and read in permuted order. The deinterleaver RAM is written at the permuted address and read in natural order. The permutation is not computed. It is held in an address table that software or an upstream loader fills during an initialisation phase. While that phase lasts, the table-load line is high. The line drops as soon as the last entry has been written. After that the table is frozen until reset. A table load line that never drops would keep rewriting the table and the data would never come back into order.

The soft-output decoder sits between the interleaver read and the deinterleaver write. Its processing takes a fixed number of cycles, so the deinterleaver address stream is replayed that many cycles after the interleaver stream. The replayed stream carries the valid flag and the block-start marker with it. Without this delay only an identity table appears to work; a scattered table corrupts the output. A registered output multiplexer passes on either the deinterleaved data or the stream taken directly from the decoder.

Each `step` pulse in the run phase advances the block index by one. The index wraps at the block length (2^AW entries; AW=16 gives 65536). The controller has two named states:
- LOAD is entered from reset.
- LOAD moves to RUN on the accepted write that completes the table.
- RUN stays in RUN until reset.

Top module: `ilv_addr_seq`

## Requirements
- R1: After reset, `tbl_init` is 1, `tbl_ready` is 0, `il_valid` and `dl_valid` are 0 and `out_data` is 0.
- R2: Every `ld_we` cycle in LOAD writes `ld_data` into table entry `ld_addr` and counts as one write. In the cycle after the 2^AW-th counted write, `tbl_init` is 0 and `tbl_ready` is 1. Neither changes again until reset.
- R3: `ld_we` pulses once `tbl_init` is 0 leave the table unchanged. Later interleaver read addresses still show the values loaded during LOAD.
- R4: While `tbl_init` is 1, `step` is ignored. `il_valid` stays 0, and the first step in RUN uses index 0.
- R5: In RUN, a `step` with block index k gives, one cycle later, `il_valid`=1, `il_wr_addr`=k and `il_rd_addr`=table[k]. Without `step`, `il_valid` is 0 one cycle later and both addresses hold their values.
- R6: The block index counts 0,1,…,2^AW−1 and then wraps to 0. `il_sof` is 1 on a valid cycle exactly when `il_wr_addr` is 0.
- R7: `dl_valid`, `dl_sof`, `dl_wr_addr` and `dl_rd_addr` equal `il_valid`, `il_sof`, `il_rd_addr` and `il_wr_addr`, in that order of pairing, exactly LAT cycles earlier.
- R8: `out_data` is a register. One cycle after `byp_sel`=1 it holds the previous `dec_data`; one cycle after `byp_sel`=0 it holds the previous `dint_data`.
- R9: Suppose a counting sequence is written into the interleaver RAM at `il_wr_addr` and read at `il_rd_addr`. Suppose it is then written into the deinterleaver RAM at `dl_wr_addr` LAT cycles later. After one full block, entry j of the deinterleaver RAM holds j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Table write strobe |
| ld_addr | input | AW | Table entry being written |
| ld_data | input | AW | Permuted address stored in that entry |
| tbl_init | output | 1 | High while the table is being loaded |
| tbl_ready | output | 1 | High once the table is complete |
| step | input | 1 | Advance the block index by one |
| il_valid | output | 1 | Interleaver address pair valid |
| il_sof | output | 1 | Interleaver pair is the first of a block |
| il_wr_addr | output | AW | Interleaver RAM write address (natural) |
| il_rd_addr | output | AW | Interleaver RAM read address (permuted) |
| dl_valid | output | 1 | Deinterleaver address pair valid |
| dl_sof | output | 1 | Deinterleaver pair is the first of a block |
| dl_wr_addr | output | AW | Deinterleaver RAM write address (permuted) |
| dl_rd_addr | output | AW | Deinterleaver RAM read address (natural) |
| byp_sel | input | 1 | 1 selects the direct decoder stream |
| dint_data | input | DW | Data read from the deinterleaver RAM |
| dec_data | input | DW | Data taken directly from the decoder |
| out_data | output | DW | Selected stream, registered |

## Verification
The properties assume that `step` is a single-cycle advance request that can arrive in any cycle, including during LOAD. They also assume that `ld_we` can arrive at any time after the table is complete. The stimulus loads the table in a shuffled address order, with idle gaps and stray steps mixed in. Each address is written exactly once, so the table is a true permutation, which the round-trip check needs. After loading, steps arrive on about three cycles in four, and the select and data inputs are random. A directed burst of late table writes and a long idle stretch cover the cases where an input must be ignored or the outputs must hold.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [0:0] {
        S_LOAD = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/ilv_table.sv
// Permutation store: one write port used during loading, one registered read port.
module ilv_table #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/ilv_ctrl.sv
// Load/run controller plus block index and natural-order address register.
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          step,
    output logic          tbl_init,
    output logic          tbl_ready,
    output logic          tbl_wr_en,
    output logic          adv,
    output logic [AW-1:0] idx,
    output logic          il_valid,
    output logic          il_sof,
    output logic [AW-1:0] il_wr_addr
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    seq_state_e    state;
    seq_state_e    nxt;
    logic [AW-1:0] ld_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_LOAD;
        end else begin
            state <= nxt;
        end
    end

    // transitions: LOAD -> RUN on the write that completes the table
    always_comb begin
        nxt = state;
        unique case (state)
            S_LOAD: if (ld_we && (ld_cnt == LAST)) nxt = S_RUN;
            S_RUN:  nxt = S_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        tbl_init  = 1'b0;
        tbl_ready = 1'b0;
        tbl_wr_en = 1'b0;
        adv       = 1'b0;
        unique case (state)
            S_LOAD: begin
                tbl_init  = 1'b1;
                tbl_wr_en = ld_we;
            end
            S_RUN: begin
                tbl_ready = 1'b1;
                adv       = step;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_cnt     <= '0;
            idx        <= '0;
            il_valid   <= 1'b0;
            il_sof     <= 1'b0;
            il_wr_addr <= '0;
        end else begin
            il_valid <= adv;
            if (tbl_wr_en) begin
                ld_cnt <= ld_cnt + 1'b1;
            end
            if (adv) begin
                idx        <= idx + 1'b1;
                il_wr_addr <= idx;
                il_sof     <= (idx == '0);
            end
        end
    end
endmodule

// File: rtl/ilv_delay.sv
// Fixed-latency replay of valid, block-start and address fields.
module ilv_delay #(
    parameter int W   = 20,
    parameter int LAT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_sof,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic         out_sof,
    output logic [W-1:0] out_data
);
    localparam int SW = W + 2;

    generate
        if (LAT == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_sof   = in_sof;
            assign out_data  = in_data;
        end else begin : g_shift
            logic [SW-1:0] stg [LAT];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < LAT; i++) begin
                        stg[i] <= '0;
                    end
                end else begin
                    stg[0] <= {in_valid, in_sof, in_data};
                    for (int i = 1; i < LAT; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign out_valid = stg[LAT-1][SW-1];
            assign out_sof   = stg[LAT-1][SW-2];
            assign out_data  = stg[LAT-1][W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ilv_addr_seq.sv
// Top: table, controller, decoder-latency delay line and output select.
module ilv_addr_seq #(
    parameter int AW  = 10,
    parameter int DW  = 8,
    parameter int LAT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [AW-1:0] ld_data,
    output logic          tbl_init,
    output logic          tbl_ready,
    input  logic          step,
    output logic          il_valid,
    output logic          il_sof,
    output logic [AW-1:0] il_wr_addr,
    output logic [AW-1:0] il_rd_addr,
    output logic          dl_valid,
    output logic          dl_sof,
    output logic [AW-1:0] dl_wr_addr,
    output logic [AW-1:0] dl_rd_addr,
    input  logic          byp_sel,
    input  logic [DW-1:0] dint_data,
    input  logic [DW-1:0] dec_data,
    output logic [DW-1:0] out_data
);
    localparam int PW = 2 * AW;

    logic          tbl_wr_en;
    logic          adv;
    logic [AW-1:0] idx;
    logic [PW-1:0] dly_out;

    ilv_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .step       (step),
        .tbl_init   (tbl_init),
        .tbl_ready  (tbl_ready),
        .tbl_wr_en  (tbl_wr_en),
        .adv        (adv),
        .idx        (idx),
        .il_valid   (il_valid),
        .il_sof     (il_sof),
        .il_wr_addr (il_wr_addr)
    );

    ilv_table #(.AW(AW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_en   (adv),
        .rd_addr (idx),
        .rd_data (il_rd_addr)
    );

    // permuted address becomes the deinterleaver write, natural one its read
    ilv_delay #(.W(PW), .LAT(LAT)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (il_valid),
        .in_sof    (il_sof),
        .in_data   ({il_rd_addr, il_wr_addr}),
        .out_valid (dl_valid),
        .out_sof   (dl_sof),
        .out_data  (dly_out)
    );

    assign dl_wr_addr = dly_out[PW-1:AW];
    assign dl_rd_addr = dly_out[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else begin
            out_data <= byp_sel ? dec_data : dint_data;
        end
    end
endmodule

// File: rtl/ilv_addr_seq_chk.sv
module ilv_addr_seq_chk #(
    parameter int AW  = 10,
    parameter int DW  = 8,
    parameter int LAT = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tbl_init,
    input logic          step,
    input logic          il_valid,
    input logic          il_sof,
    input logic [AW-1:0] il_wr_addr,
    input logic          dl_valid,
    input logic          dl_sof,
    input logic [AW-1:0] dl_rd_addr,
    input logic          byp_sel,
    input logic [DW-1:0] dint_data,
    input logic [DW-1:0] dec_data,
    input logic [DW-1:0] out_data
);
    logic [31:0] il_cnt;
    logic [31:0] dl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            il_cnt <= '0;
            dl_cnt <= '0;
        end else begin
            il_cnt <= il_cnt + {31'd0, il_valid};
            dl_cnt <= dl_cnt + {31'd0, dl_valid};
        end
    end

    a_r2_init_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_init |=> !tbl_init);

    a_r4_no_issue_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_init |=> !il_valid);

    a_r5_step_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_init && step) |=> il_valid);

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> (!il_valid && $stable(il_wr_addr)));

    a_r6_sof_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        il_valid |-> (il_sof == (il_wr_addr == '0)));

    a_r7_sof_replayed: assert property (@(posedge clk) disable iff (!rst_n)
        dl_valid |-> (dl_sof == (dl_rd_addr == '0)));

    a_r7_lag_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_cnt <= il_cnt) && ((il_cnt - dl_cnt) <= 32'(LAT)));

    a_r8_bypass_path: assert property (@(posedge clk) disable iff (!rst_n)
        byp_sel |=> (out_data == $past(dec_data)));

    a_r8_deint_path: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_sel |=> (out_data == $past(dint_data)));
endmodule

bind ilv_addr_seq ilv_addr_seq_chk #(.AW(AW), .DW(DW), .LAT(LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_init   (tbl_init),
    .step       (step),
    .il_valid   (il_valid),
    .il_sof     (il_sof),
    .il_wr_addr (il_wr_addr),
    .dl_valid   (dl_valid),
    .dl_sof     (dl_sof),
    .dl_rd_addr (dl_rd_addr),
    .byp_sel    (byp_sel),
    .dint_data  (dint_data),
    .dec_data   (dec_data),
    .out_data   (out_data)
);

// File: tb/ilv_addr_seq_test.sv
module ilv_addr_seq_test;
    localparam int AW     = 10;
    localparam int DW     = 8;
    localparam int LAT    = 6;
    localparam int N      = 1 << AW;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [AW-1:0] ld_data = '0;
    logic          tbl_init, tbl_ready;
    logic          step = 1'b0;
    logic          il_valid, il_sof, dl_valid, dl_sof;
    logic [AW-1:0] il_wr_addr, il_rd_addr, dl_wr_addr, dl_rd_addr;
    logic          byp_sel = 1'b0;
    logic [DW-1:0] dint_data = '0;
    logic [DW-1:0] dec_data = '0;
    logic [DW-1:0] out_data;

    ilv_addr_seq #(.AW(AW), .DW(DW), .LAT(LAT)) uut (.*);

    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    int            perm  [N];
    int            order [N];
    int            tbl_m [N];
    int            ram_b [N];
    int            loaded = 0;
    int            wcnt   = 0;
    int            idx_m  = 0;
    int            cyc    = 0;
    int            e_v = 0, e_s = 0, e_w = 0, e_r = 0;
    int            hv [64];
    int            hs [64];
    int            hw [64];
    int            hr [64];
    int            yq [64];
    string         rd_tag = "R5";

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int rnd(input int n);
        return int'($urandom % n);
    endfunction

    task automatic shuffle(ref int a [N]);
        for (int i = 0; i < N; i++) a[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            int j = rnd(i + 1);
            int t = a[i];
            a[i] = a[j];
            a[j] = t;
        end
    endtask

    task automatic tick(input bit st, input bit we, input int wa, input int wd,
                        input bit bs, input int di, input int dc);
        int exp_out;
        int sl, ps;
        step      = st;
        ld_we     = we;
        ld_addr   = AW'(wa);
        ld_data   = AW'(wd);
        byp_sel   = bs;
        dint_data = DW'(di);
        dec_data  = DW'(dc);
        exp_out   = bs ? (dc % (1 << DW)) : (di % (1 << DW));
        if (loaded != 0 && st) begin
            e_v = 1; e_w = idx_m; e_r = tbl_m[idx_m]; e_s = (idx_m == 0) ? 1 : 0;
            idx_m = (idx_m + 1) % N;
        end else begin
            e_v = 0;
        end
        if (loaded == 0 && we) begin
            tbl_m[wa] = wd;
            wcnt++;
            if (wcnt == N) loaded = 1;
        end
        @(negedge clk);
        cyc++;
        sl = cyc % 64;
        ps = (cyc - LAT + 64) % 64;
        hv[sl] = e_v; hs[sl] = e_s; hw[sl] = e_w; hr[sl] = e_r;
        // R2 load status
        chk("R2 tbl_init", int'(tbl_init), (loaded == 0) ? 1 : 0);
        chk("R2 tbl_ready", int'(tbl_ready), loaded);
        // R4/R5 issue
        chk((loaded == 0) ? "R4 il_valid" : "R5 il_valid", int'(il_valid), e_v);
        chk("R5 il_wr_addr", int'(il_wr_addr), e_w);
        chk(rd_tag == "R3" ? "R3 il_rd_addr" : "R5 il_rd_addr", int'(il_rd_addr), e_r);
        if (e_v != 0) chk("R6 il_sof", int'(il_sof), e_s);
        // R7 replay
        chk("R7 dl_valid", int'(dl_valid), hv[ps]);
        if (hv[ps] != 0) begin
            chk("R7 dl_sof", int'(dl_sof), hs[ps]);
            chk("R7 dl_wr_addr", int'(dl_wr_addr), hr[ps]);
            chk("R7 dl_rd_addr", int'(dl_rd_addr), hw[ps]);
        end
        // R8 select
        chk("R8 out_data", int'(out_data), exp_out);
        // R9 round trip: interleaver RAM holds counting data, so its read value equals its address
        if (il_valid) yq[sl] = int'(il_rd_addr);
        if (dl_valid) ram_b[int'(dl_wr_addr)] = yq[ps];
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            hv[i] = 0; hs[i] = 0; hw[i] = 0; hr[i] = 0; yq[i] = 0;
        end
        for (int i = 0; i < N; i++) begin
            ram_b[i] = -1;
            tbl_m[i] = 0;
        end
        void'($urandom(32'd20250));
        shuffle(perm);
        shuffle(order);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 tbl_init", int'(tbl_init), 1);
        chk("R1 tbl_ready", int'(tbl_ready), 0);
        chk("R1 il_valid", int'(il_valid), 0);
        chk("R1 dl_valid", int'(dl_valid), 0);
        chk("R1 out_data", int'(out_data), 0);

        // load phase with gaps and stray steps (R4)
        for (int i = 0; i < N; i++) begin
            while (rnd(4) == 0) tick(rnd(2) == 1, 1'b0, 0, 0, rnd(2) == 1, rnd(256), rnd(256));
            tick(rnd(2) == 1, 1'b1, order[i], perm[order[i]], rnd(2) == 1, rnd(256), rnd(256));
        end

        // random run (R5 R6 R7 R8)
        for (int i = 0; i < 3 * N; i++) begin
            tick(rnd(4) != 0, 1'b0, 0, 0, rnd(2) == 1, rnd(256), rnd(256));
        end

        // late table writes must be ignored (R3)
        rd_tag = "R3";
        for (int i = 0; i < 24; i++) begin
            tick(1'b0, 1'b1, rnd(N), rnd(N), rnd(2) == 1, rnd(256), rnd(256));
        end
        for (int i = 0; i < N + 64; i++) begin
            tick(1'b1, 1'b0, 0, 0, rnd(2) == 1, rnd(256), rnd(256));
        end
        rd_tag = "R5";

        // long idle: outputs hold (R5), replay drains (R7)
        for (int i = 0; i < 20; i++) begin
            tick(1'b0, 1'b0, 0, 0, 1'b1, 8'hA5, 8'h3C);
        end

        // R9 round trip recovers natural order
        for (int j = 0; j < N; j++) begin
            if (ram_b[j] != j) begin
                chk("R9 deinterleaved entry", ram_b[j], j);
            end else begin
                checks++;
            end
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule